// File: doc/BRIEF.md
# Shrinking-Radius Nearest-Neighbour Collector

This block gathers the k closest candidate points for one spatial search query. A traversal engine sends it one candidate per clock cycle. Each candidate is a point pointer paired with a squared distance, taken from the leaves of a space-partitioning tree. The block keeps the k smallest candidates in ascending distance order. It also drives back a pruning radius, so the traversal can skip subtrees that cannot hold a closer point.

The radius begins at all-ones, which stands for "infinite". In nearest-k mode it stays there until k entries are held. From then on it follows the distance of the farthest kept entry, so it shrinks as closer points arrive. In fixed-radius mode the radius is loaded at the clear strobe and never changes. Entries are then kept only until the queue is full, and nothing is evicted. After the query-done strobe the contents are frozen. They are read out nearest first through an index port. One instance serves one search thread.

Top module: `knn_queue`

## Requirements
- R1: After reset or a clear strobe (`clear_i`=1), `count_o` is 0, `result_valid_o` is 0, and `radius_o` is all-ones in nearest-k mode. The change is visible on the cycle after the strobe.
- R2: A candidate is accepted only when `cand_valid_i`=1, `cand_dist_i` < `radius_o`, and the query is not done. A rejected candidate leaves the count, the radius and every entry unchanged.
- R3: Held entries are in non-decreasing distance order from index 0. A candidate whose distance equals a held one is placed after all entries with that distance, so older entries come first.
- R4: In nearest-k mode, a candidate accepted while K entries are held evicts the entry at index K-1. `count_o` never exceeds K.
- R5: In nearest-k mode, `radius_o` is all-ones while fewer than K entries are held. With K entries held it equals the distance at index K-1.
- R6: One candidate can be accepted on every clock cycle. Its effect on entries, count and radius is visible on the cycle after it is presented.
- R7: A clear strobe with `mode_fixed_i`=1 selects fixed-radius mode and loads `radius_o` from `fixed_radius_i`. In that mode the radius stays constant, and candidates that arrive while K entries are held are dropped.
- R8: `done_i` raises `result_valid_o` on the next cycle. A candidate presented on the same cycle as `done_i` is still processed. Later candidates are ignored until the next clear strobe.
- R9: `rd_ptr_o` and `rd_dist_o` show the entry at index `rd_idx_i`, where index 0 is the nearest. An index at or above `count_o` reads as zero.
- R10: A clear strobe takes priority over a candidate presented in the same cycle. That candidate is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Start a new query: empty the queue and load the radius |
| mode_fixed_i | input | 1 | Sampled at clear: 1 selects fixed-radius mode, 0 selects nearest-k mode |
| fixed_radius_i | input | DIST_W | Radius loaded at clear in fixed-radius mode |
| cand_valid_i | input | 1 | Candidate present this cycle |
| cand_ptr_i | input | PTR_W | Candidate point pointer |
| cand_dist_i | input | DIST_W | Candidate squared distance |
| done_i | input | 1 | Query finished; freeze the result |
| radius_o | output | DIST_W | Current pruning radius |
| count_o | output | $clog2(K+1) | Number of entries held |
| result_valid_o | output | 1 | Result frozen and ready to read |
| rd_idx_i | input | $clog2(K) | Readout index, 0 is the nearest |
| rd_ptr_o | output | PTR_W | Pointer at the readout index |
| rd_dist_o | output | DIST_W | Distance at the readout index |

## Verification
The hardest states to reach are the ones where the queue is full and a candidate lands exactly on a tie or on the boundary. This covers a distance equal to the current radius, and duplicates of the entry about to be evicted. The random stimulus therefore draws distances from a narrow range of 64 values, so ties and radius-equal candidates occur many times per query. Directed sequences add three more cases: a clear in the same cycle as a candidate, a candidate arriving alongside done, and a fixed-radius query filled past capacity.

// File: rtl/knn_queue.sv
module knn_queue #(
  parameter int K      = 8,
  parameter int PTR_W  = 16,
  parameter int DIST_W = 24,
  localparam int CNT_W = $clog2(K + 1),
  localparam int IDX_W = $clog2(K)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              mode_fixed_i,
  input  logic [DIST_W-1:0] fixed_radius_i,
  input  logic              cand_valid_i,
  input  logic [PTR_W-1:0]  cand_ptr_i,
  input  logic [DIST_W-1:0] cand_dist_i,
  input  logic              done_i,
  output logic [DIST_W-1:0] radius_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              result_valid_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic [DIST_W-1:0] rd_dist_o
);

  logic [PTR_W-1:0]    ptr_q   [K];
  logic [DIST_W-1:0]   dist_q  [K];
  logic [PTR_W-1:0]    nxt_ptr [K];
  logic [DIST_W-1:0]   nxt_dist[K];
  logic [K*DIST_W-1:0] dist_flat;
  logic [CNT_W-1:0]    count_q, pos, cnt_next;
  logic [DIST_W-1:0]   radius_q;
  logic                fixed_q, done_q, full, accept;

  assign full     = count_q == CNT_W'(K);
  assign cnt_next = full ? count_q : count_q + 1'b1;
  assign accept   = cand_valid_i && !done_q && (cand_dist_i < radius_q) && !(fixed_q && full);

  always_comb begin
    pos = '0;
    for (int i = 0; i < K; i++)
      if ((CNT_W'(i) < count_q) && (dist_q[i] <= cand_dist_i))
        pos = pos + 1'b1;
  end

  for (genvar gi = 0; gi < K; gi++) begin : g_slot
    if (gi == 0) begin : g_head
      assign nxt_ptr[gi]  = (pos == '0) ? cand_ptr_i  : ptr_q[gi];
      assign nxt_dist[gi] = (pos == '0) ? cand_dist_i : dist_q[gi];
    end else begin : g_tail
      assign nxt_ptr[gi]  = (CNT_W'(gi) < pos)  ? ptr_q[gi]  :
                            (CNT_W'(gi) == pos) ? cand_ptr_i : ptr_q[gi-1];
      assign nxt_dist[gi] = (CNT_W'(gi) < pos)  ? dist_q[gi]  :
                            (CNT_W'(gi) == pos) ? cand_dist_i : dist_q[gi-1];
    end
    assign dist_flat[gi*DIST_W +: DIST_W] = dist_q[gi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      radius_q <= '1;
      fixed_q  <= 1'b0;
      done_q   <= 1'b0;
      for (int i = 0; i < K; i++) begin
        ptr_q[i]  <= '0;
        dist_q[i] <= '0;
      end
    end else if (clear_i) begin
      count_q  <= '0;
      fixed_q  <= mode_fixed_i;
      radius_q <= mode_fixed_i ? fixed_radius_i : '1;
      done_q   <= 1'b0;
    end else begin
      if (done_i) done_q <= 1'b1;
      if (accept) begin
        for (int i = 0; i < K; i++) begin
          ptr_q[i]  <= nxt_ptr[i];
          dist_q[i] <= nxt_dist[i];
        end
        count_q <= cnt_next;
        if (!fixed_q)
          radius_q <= (cnt_next == CNT_W'(K)) ? nxt_dist[K-1] : '1;
      end
    end
  end

  assign radius_o       = radius_q;
  assign count_o        = count_q;
  assign result_valid_o = done_q;
  assign rd_ptr_o       = (CNT_W'(rd_idx_i) < count_q) ? ptr_q[rd_idx_i]  : '0;
  assign rd_dist_o      = (CNT_W'(rd_idx_i) < count_q) ? dist_q[rd_idx_i] : '0;

endmodule

module knn_queue_chk #(
  parameter int K      = 8,
  parameter int DIST_W = 24,
  parameter int CNT_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clear_i,
  input logic                cand_valid_i,
  input logic [DIST_W-1:0]   cand_dist_i,
  input logic [DIST_W-1:0]   radius_o,
  input logic [CNT_W-1:0]    count_o,
  input logic                result_valid_o,
  input logic                fixed_q,
  input logic [K*DIST_W-1:0] dist_flat
);

  // R4
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(K));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ({1'b0, count_o} <= {1'b0, $past(count_o)} + 1'b1));

  // R1
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0) && !result_valid_o);

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && cand_valid_i && cand_dist_i >= radius_o)
      |=> $stable(count_o) && $stable(radius_o) && $stable(dist_flat));

  // R5
  radius_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> radius_o <= $past(radius_o));

  // R5
  radius_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fixed_q && count_o == CNT_W'(K)) |-> radius_o == dist_flat[(K-1)*DIST_W +: DIST_W]);

  // R7
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_q && !clear_i) |=> $stable(radius_o));

  // R8
  done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && !clear_i) |=> $stable(count_o) && $stable(dist_flat));

  // R3
  always @(negedge clk)
    if (rst_n)
      for (int i = 0; i + 1 < K; i++)
        if (CNT_W'(i + 1) < count_o)
          order_chk: assert (dist_flat[i*DIST_W +: DIST_W] <= dist_flat[(i+1)*DIST_W +: DIST_W]);

endmodule

bind knn_queue knn_queue_chk #(.K(K), .DIST_W(DIST_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .cand_valid_i(cand_valid_i),
  .cand_dist_i(cand_dist_i), .radius_o(radius_o), .count_o(count_o),
  .result_valid_o(result_valid_o), .fixed_q(fixed_q), .dist_flat(dist_flat)
);

// File: tb/tb_knn_queue.sv
`timescale 1ns/10ps
module tb_knn_queue;
  localparam int K = 8, PW = 16, DW = 24, CW = 4, IW = 3;
  localparam logic [DW-1:0] INF = '1;

  logic clk = 0, rst_n = 0, clear_i = 0, mode_fixed_i = 0, cand_valid_i = 0, done_i = 0;
  logic [DW-1:0] fixed_radius_i = '0, cand_dist_i = '0, radius_o, rd_dist_o;
  logic [PW-1:0] cand_ptr_i = '0, rd_ptr_o;
  logic [CW-1:0] count_o;
  logic [IW-1:0] rd_idx_i = '0;
  logic result_valid_o;

  int n_tests = 0, n_fail = 0;
  logic [PW-1:0] m_ptr [K];
  logic [DW-1:0] m_dist[K];
  int m_cnt = 0;
  logic [DW-1:0] m_rad = INF;
  bit m_fixed = 0, m_done = 0;

  knn_queue #(.K(K), .PTR_W(PW), .DIST_W(DW)) dut (.*);

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input bit v, input logic [PW-1:0] p, input logic [DW-1:0] d,
                       input bit dn, input bit clr, input bit md, input logic [DW-1:0] fr);
    if (clr) begin
      m_cnt = 0; m_fixed = md; m_rad = md ? fr : INF; m_done = 0;
    end else begin
      if (v && !m_done && d < m_rad && !(m_fixed && m_cnt == K)) begin
        int pos = 0;
        for (int i = 0; i < m_cnt; i++) if (m_dist[i] <= d) pos++;
        for (int i = K - 1; i > pos; i--) begin m_ptr[i] = m_ptr[i-1]; m_dist[i] = m_dist[i-1]; end
        m_ptr[pos] = p; m_dist[pos] = d;
        if (m_cnt < K) m_cnt++;
        if (!m_fixed) m_rad = (m_cnt == K) ? m_dist[K-1] : INF;
      end
      if (dn) m_done = 1;
    end
  endtask

  task automatic step(input bit v, input logic [PW-1:0] p, input logic [DW-1:0] d,
                      input bit dn, input bit clr, input bit md, input logic [DW-1:0] fr);
    @(negedge clk);
    cand_valid_i = v; cand_ptr_i = p; cand_dist_i = d; done_i = dn;
    clear_i = clr; mode_fixed_i = md; fixed_radius_i = fr;
    @(posedge clk);
    model(v, p, d, dn, clr, md, fr);
    #1;
    chk("R5/R7 radius", 64'(radius_o), 64'(m_rad));
    chk("R4/R6 count", 64'(count_o), 64'(m_cnt));
    chk("R8 result_valid", 64'(result_valid_o), 64'(m_done));
  endtask

  task automatic idle();
    step(0, '0, '0, 0, 0, 0, '0);
  endtask

  task automatic cand(input logic [PW-1:0] p, input logic [DW-1:0] d);
    step(1, p, d, 0, 0, 0, '0);
  endtask

  task automatic readout();
    for (int i = 0; i < K; i++) begin
      rd_idx_i = IW'(i);
      #0.1;
      chk("R9/R3 rd_ptr", 64'(rd_ptr_o), (i < m_cnt) ? 64'(m_ptr[i]) : 64'd0);
      chk("R9/R3 rd_dist", 64'(rd_dist_o), (i < m_cnt) ? 64'(m_dist[i]) : 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0.5;
    chk("R1 reset count", 64'(count_o), 64'd0);
    chk("R1 reset radius", 64'(radius_o), 64'(INF));
    chk("R1 reset valid", 64'(result_valid_o), 64'd0);

    // R2: all-ones distance never below infinite radius
    cand(16'h11, INF);
    chk("R2 reject inf", 64'(count_o), 64'd0);
    // R3: ties keep insertion order
    cand(16'h1, 24'd5); cand(16'h2, 24'd5); cand(16'h3, 24'd3);
    readout();
    // R6: back-to-back fill, R4 eviction, R5 radius
    for (int i = 0; i < 10; i++) cand(PW'(16'h20 + i), DW'(40 - 2 * i));
    readout();
    // R2: equal to radius rejected
    cand(16'h77, m_rad);
    readout();
    // R10: clear beats candidate
    step(1, 16'h55, 24'd1, 0, 1, 0, '0);
    chk("R10 clear priority", 64'(count_o), 64'd0);
    // R8: candidate with done accepted, later ignored
    cand(16'h9, 24'd9);
    step(1, 16'hA, 24'd4, 1, 0, 0, '0);
    cand(16'hB, 24'd2);
    chk("R8 ignored after done", 64'(count_o), 64'd2);
    readout();
    // R7: fixed radius, overfill
    step(0, '0, '0, 0, 1, 1, 24'd30);
    for (int i = 0; i < 12; i++) cand(PW'(i), DW'(i * 3));
    readout();

    for (int q = 0; q < 60; q++) begin
      bit md = ($urandom % 4) == 0;
      int n = 5 + $urandom % 30;
      step(0, '0, '0, 0, 1, md, DW'($urandom % 64));
      for (int j = 0; j < n; j++) begin
        if ($urandom % 5 == 0) idle();
        else if ($urandom % 8 == 0) cand(PW'($urandom), m_rad);
        else step(1, PW'($urandom), DW'($urandom % 64), ($urandom % 40) == 0, 0, 0, '0);
        if ($urandom % 6 == 0) readout();
      end
      step(0, '0, '0, 1, 0, 0, '0);
      idle();
      readout();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule